// File: doc/BRIEF.md
# SMBus Byte-Protocol Register Target

This block is a slave-only SMBus target. It gives a bus host byte-wide read and write access to a register file that sits beside it on a simple parallel port. Four transactions are understood: Write Byte, Read Byte, Send Byte and Receive Byte. An 8-bit register pointer survives from one transaction to the next. A Send Byte (or the first half of a Read Byte) loads the pointer, and a Receive Byte reads the register it names.

The bus pins are open-drain in style. SCL and SDA come in as sampled inputs, and the block pulls SDA low through an output-enable. It never drives SCL, because it does not stretch the clock. Both lines pass through a short synchroniser. Bus conditions are then derived in the system clock domain: START and STOP are SDA edges while SCL is high, and rising and falling edges of SCL clock the data. The low bit of the 7-bit target address comes from a strap input, which is taken once, right after reset.

A write reaches the register file only as one write-strobe pulse, issued at the STOP that closes a complete and well-formed Write Byte. Any shorter, longer or interrupted sequence leaves the register file untouched.

Top module: `smb_byte_target`

## Requirements
- R1: The target answers to the 7-bit address 010110x (address bits 6..0, followed on the wire by the R/W bit, where 1 means read). x is the `a0_strap` level taken on the first clock after reset is released. Later changes of the strap have no effect until the next reset.
- R2: The target ACKs a matching address byte and every byte the host writes after it by asserting `sda_oe` through the ninth SCL clock of that byte. It releases SDA after that clock.
- R3: A complete Write Byte (address with R/W=0, register byte, data byte, each ACKed, then STOP) produces exactly one `reg_we` pulse, one clock long, after the STOP. During that pulse `reg_addr` equals the register byte and `reg_wdata` equals the data byte.
- R4: No `reg_we` pulse occurs, and the register keeps its value, if a write is cut short by STOP before its data byte has been ACKed, if any further SCL clock follows the data ACK, or if a repeated START replaces the closing STOP.
- R5: In a Read Byte, after the repeated START and the address with R/W=1, the target shifts out the register named by the register byte, MSB first. It releases SDA after the eighth bit, whatever the host answers.
- R6: The register byte of any matched write-direction transaction loads the pointer, which is `reg_addr`. The pointer is 0x00 after reset. A Receive Byte returns the register at the pointer, and reads never advance the pointer.
- R7: A START or repeated START in any state releases SDA and restarts reception of an address byte. A STOP in any state returns the target to idle.
- R8: A transaction whose address does not match is NACKed. The target then drives nothing until the next START, and neither the register file nor the pointer changes.
- R9: During and straight after reset, `sda_oe` and `reg_we` are low and `reg_addr` is 0x00.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| a0_strap | input | 1 | Strap that selects the address LSB |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Data byte of a committed write |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 8 | Register file contents at `reg_addr` (combinational) |

## Verification
The bench uses the default parameters: address upper bits 010110, a two-stage synchroniser and a pointer reset value of 0x00. With these, both strap settings can be tried through resets, so the own address and its neighbour swap between ACK and NACK. The short synchroniser puts each SDA change only a few system clocks after an SCL fall. That lets a bus half-period of ten clocks test that SDA moves only while SCL is low, and that repeated STARTs and truncations are seen at every bit position of a byte.

// File: rtl/smb_tgt_pkg.sv
`timescale 1ns/1ps
package smb_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_HOLD
  } smb_state_e;

  // Bus events derived in the system clock domain.
  typedef struct packed {
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } line_ev_t;

endpackage

// File: rtl/smb_rst_sync.sv
`timescale 1ns/1ps
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;
  logic [N-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[N-1];

endmodule

// File: rtl/smb_line_cond.sv
`timescale 1ns/1ps
module smb_line_cond
  import smb_tgt_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev
);

  localparam int D = (SYNC_DEPTH < 2) ? 2 : SYNC_DEPTH;

  logic [D-1:0] scl_sr_q, scl_sr_n;
  logic [D-1:0] sda_sr_q, sda_sr_n;
  logic         scl_d_q, sda_d_q;
  logic         scl_s, sda_s;

  always_comb begin
    scl_sr_n = {scl_sr_q[D-2:0], scl_i};
    sda_sr_n = {sda_sr_q[D-2:0], sda_i};
  end

  // Idle bus is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr_q <= '1;
      sda_sr_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sr_q <= scl_sr_n;
      sda_sr_q <= sda_sr_n;
      scl_d_q  <= scl_sr_q[D-1];
      sda_d_q  <= sda_sr_q[D-1];
    end
  end

  assign scl_s = scl_sr_q[D-1];
  assign sda_s = sda_sr_q[D-1];

  always_comb begin
    ev.sda      = sda_s;
    ev.scl_rise = scl_s & ~scl_d_q;
    ev.scl_fall = ~scl_s & scl_d_q;
    ev.start    = scl_s & scl_d_q & sda_d_q & ~sda_s;
    ev.stop     = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end

endmodule

// File: rtl/smb_addr_strap.sv
`timescale 1ns/1ps
module smb_addr_strap #(
  parameter logic [5:0] ADDR_UPPER = 6'b010110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a0_strap,
  output logic [6:0] own_addr
);

  logic taken_q, taken_n;
  logic lsb_q, lsb_n;

  always_comb begin
    taken_n = taken_q;
    lsb_n   = lsb_q;
    if (!taken_q) begin
      lsb_n   = a0_strap;
      taken_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      taken_q <= taken_n;
      lsb_q   <= lsb_n;
    end
  end

  assign own_addr = {ADDR_UPPER, lsb_q};

endmodule

// File: rtl/smb_proto_fsm.sv
`timescale 1ns/1ps
module smb_proto_fsm
  import smb_tgt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PTR_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_ev_t          ev,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  smb_state_e        st_q, st_n, nxt_q, nxt_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic [BYTE_W-1:0] wd_q, wd_n;
  logic              seen_q, seen_n;
  logic              oe_q, oe_n;
  logic              pend_q, pend_n;
  logic              we_q, we_n;
  logic              byte_full;

  assign byte_full = (cnt_q == FULL);

  always_comb begin
    st_n   = st_q;
    nxt_n  = nxt_q;
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    ptr_n  = ptr_q;
    wd_n   = wd_q;
    seen_n = seen_q;
    oe_n   = oe_q;
    pend_n = pend_q;
    we_n   = 1'b0;

    if (ev.start) begin
      // START or repeated START: always begin a new address byte.
      st_n   = ST_ADDR;
      cnt_n  = '0;
      oe_n   = 1'b0;
      pend_n = 1'b0;
    end else if (ev.stop) begin
      // Commit only a write that reached its data ACK with no further clock.
      if (st_q == ST_HOLD && pend_q) we_n = 1'b1;
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      pend_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (ev.scl_rise && !byte_full) begin
            rx_n  = {rx_q[BYTE_W-2:0], ev.sda};
            cnt_n = cnt_q + 1'b1;
          end else if (ev.scl_fall && byte_full) begin
            cnt_n  = '0;
            seen_n = 1'b0;
            st_n   = ST_ACK;
            oe_n   = 1'b1;
            if (st_q == ST_ADDR) begin
              if (rx_q[BYTE_W-1:1] == own_addr) begin
                nxt_n = rx_q[0] ? ST_TX : ST_REG;
              end else begin
                st_n = ST_HOLD;
                oe_n = 1'b0;
              end
            end else if (st_q == ST_REG) begin
              ptr_n = rx_q;
              nxt_n = ST_DATA;
            end else begin
              wd_n   = rx_q;
              pend_n = 1'b1;
              nxt_n  = ST_HOLD;
            end
          end
        end

        ST_ACK: begin
          if (ev.scl_rise) begin
            seen_n = 1'b1;
          end else if (ev.scl_fall && seen_q) begin
            st_n  = nxt_q;
            cnt_n = '0;
            if (nxt_q == ST_TX) begin
              tx_n = reg_rdata;
              oe_n = ~reg_rdata[BYTE_W-1];
            end else begin
              oe_n = 1'b0;
            end
          end
        end

        ST_TX: begin
          if (ev.scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (ev.scl_fall) begin
            if (byte_full) begin
              st_n = ST_HOLD;
              oe_n = 1'b0;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
              oe_n = ~tx_q[BYTE_W-2];
            end
          end
        end

        ST_HOLD: begin
          // Any full clock after the data ACK spoils a pending write.
          if (ev.scl_fall) pend_n = 1'b0;
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= PTR_RESET;
      wd_q   <= '0;
      seen_q <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      nxt_q  <= nxt_n;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      ptr_q  <= ptr_n;
      wd_q   <= wd_n;
      seen_q <= seen_n;
      oe_q   <= oe_n;
      pend_q <= pend_n;
      we_q   <= we_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;

endmodule

// File: rtl/smb_byte_target.sv
`timescale 1ns/1ps
module smb_byte_target
  import smb_tgt_pkg::*;
#(
  parameter logic [5:0]        ADDR_UPPER = 6'b010110,
  parameter int                SYNC_DEPTH = 2,
  parameter logic [BYTE_W-1:0] PTR_RESET  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              a0_strap,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic     rst_int_n;
  line_ev_t ev_w;
  logic [6:0] own_addr_w;

  smb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  smb_line_cond #(.SYNC_DEPTH(SYNC_DEPTH)) u_line (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev_w)
  );

  smb_addr_strap #(.ADDR_UPPER(ADDR_UPPER)) u_strap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .a0_strap (a0_strap),
    .own_addr (own_addr_w)
  );

  smb_proto_fsm #(.PTR_RESET(PTR_RESET)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ev        (ev_w),
    .own_addr  (own_addr_w),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

endmodule

// File: rtl/smb_byte_target_chk.sv
`timescale 1ns/1ps
module smb_byte_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       start_det,
  input logic       stop_det,
  input logic       fall_det
);

  // R10: SDA drive moves only while SCL is low
  p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3: the write strobe lasts one clock
  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3: the write strobe follows a STOP
  p_we_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(stop_det));

  // R6: the pointer moves only at an SCL fall
  p_ptr_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> $past(fall_det));

  // R7: a START releases SDA
  p_start_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

endmodule

bind smb_byte_target smb_byte_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .start_det (ev_w.start),
  .stop_det  (ev_w.stop),
  .fall_det  (ev_w.scl_fall)
);

// File: tb/smb_byte_target_test.sv
`timescale 1ns/1ps
module smb_byte_target_test;

  localparam int Q  = 5;
  localparam int WD = 190000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, host_scl, host_sda, a0_strap;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_bus;
  logic [7:0] rf [256];
  logic [7:0] shadow [256];
  logic       rf_ready = 1'b0;

  int n_cmp = 0, n_bad = 0, we_cnt = 0, exp_we = 0, oe_bad = 0;
  logic       a0_lat;
  logic [7:0] ptr_m;
  logic       oe_prev;
  bit         done = 1'b0;

  assign sda_bus   = host_sda & ~sda_oe;
  assign reg_rdata = rf[reg_addr];

  smb_byte_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .a0_strap(a0_strap), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 29) ^ 8'hA5;
  endfunction

  function automatic logic [6:0] own_of(input logic a0);
    return {6'b010110, a0};
  endfunction

  function automatic logic is_own(input logic [6:0] a);
    return a == own_of(a0_lat);
  endfunction

  // Register file beside the target, written only by its strobe.
  always @(negedge clk) begin
    if (!rf_ready) begin
      for (int i = 0; i < 256; i++) rf[i] = init_val(i);
      rf_ready = 1'b1;
    end else if (rst_n && reg_we) begin
      rf[reg_addr] = reg_wdata;
      we_cnt++;
    end
  end

  // R10 monitor: drive changes while SCL high are counted.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== oe_prev && host_scl) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic v, output logic s);
    wt(Q); host_sda = v; wt(Q); host_scl = 1'b1; wt(Q); s = sda_bus; wt(Q); host_scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(~host_ack, s);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; host_scl = 1'b1; wt(2*Q); host_sda = 1'b0; wt(2*Q); host_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    wt(Q); host_sda = 1'b1; wt(Q); host_scl = 1'b1; wt(Q); host_sda = 1'b0; wt(Q); host_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); host_sda = 1'b0; wt(Q); host_scl = 1'b1; wt(Q); host_sda = 1'b1; wt(2*Q);
  endtask

  task automatic do_reset(input logic a0);
    @(negedge clk); rst_n = 1'b0; a0_strap = a0; host_scl = 1'b1; host_sda = 1'b1;
    wt(4); rst_n = 1'b1; a0_lat = a0; ptr_m = 8'h00; wt(6);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d, input string req);
    logic k0, k1, k2, e;
    e = is_own(a);
    bus_start(); put_byte({a, 1'b0}, k0); put_byte(r, k1); put_byte(d, k2); bus_stop();
    chk(req, "write address ack", k0, e);
    chk("R2", "write register ack", k1, e);
    chk("R2", "write data ack", k2, e);
    if (e) begin shadow[r] = d; ptr_m = r; exp_we++; end
  endtask

  task automatic t_read(input logic [6:0] a, input logic [7:0] r, input logic hack, input string req);
    logic k0, k1, k2, e; logic [7:0] v;
    e = is_own(a);
    bus_start(); put_byte({a, 1'b0}, k0); put_byte(r, k1);
    bus_rstart(); put_byte({a, 1'b1}, k2); get_byte(hack, v); bus_stop();
    chk("R2", "read address ack", k0, e);
    chk("R7", "address ack after repeated start", k2, e);
    if (e) ptr_m = r;
    chk(req, "read byte data", v, e ? shadow[r] : 8'hFF);
  endtask

  task automatic t_send(input logic [6:0] a, input logic [7:0] r);
    logic k0, k1, e;
    e = is_own(a);
    bus_start(); put_byte({a, 1'b0}, k0); put_byte(r, k1); bus_stop();
    chk("R2", "send byte register ack", k1, e);
    if (e) ptr_m = r;
  endtask

  task automatic t_recv(input logic [6:0] a, input string req);
    logic k0, e; logic [7:0] v;
    e = is_own(a);
    bus_start(); put_byte({a, 1'b1}, k0); get_byte(1'b0, v); bus_stop();
    chk("R2", "receive address ack", k0, e);
    chk(req, "receive byte data", v, e ? shadow[ptr_m] : 8'hFF);
  endtask

  // kind 0: STOP inside data byte, 1: extra clock after data ACK,
  // 2: repeated START instead of STOP, 3: STOP inside register byte
  task automatic t_trunc(input logic [7:0] r, input logic [7:0] d, input int kind, input int k);
    logic kk, s; logic [6:0] a;
    a = own_of(a0_lat);
    bus_start(); put_byte({a, 1'b0}, kk);
    if (kind == 3) begin
      for (int i = 0; i < k; i++) bit_io(r[7-i], s);
      bus_stop();
    end else begin
      put_byte(r, kk);
      if (kind == 0) begin
        for (int i = 0; i < k; i++) bit_io(d[7-i], s);
      end else begin
        put_byte(d, kk);
        if (kind == 1) bit_io(1'b1, s);
        else bus_rstart();
      end
      bus_stop();
      ptr_m = r;
    end
  endtask

  initial begin
    logic [6:0] a, oth;
    logic [7:0] r;
    int op;
    void'($urandom(32'h5EED_0123));
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    rst_n = 1'b0; host_scl = 1'b1; host_sda = 1'b1; a0_strap = 1'b1;
    a0_lat = 1'b1; ptr_m = 8'h00;
    wt(3);
    chk("R9", "sda_oe in reset", sda_oe, 1'b0);
    chk("R9", "reg_we in reset", reg_we, 1'b0);
    do_reset(1'b1);
    chk("R9", "sda_oe after reset", sda_oe, 1'b0);
    chk("R9", "reg_addr after reset", reg_addr, 8'h00);

    // Strap high: own address 0x2D, neighbour 0x2C refused.
    t_write(7'h2D, 8'h10, 8'h3C, "R1");
    t_read(7'h2D, 8'h10, 1'b0, "R3");
    t_write(7'h2C, 8'h11, 8'h77, "R1");
    t_read(7'h2D, 8'h11, 1'b0, "R8");
    // Boundary register addresses and data patterns.
    t_write(7'h2D, 8'hFF, 8'h80, "R3");
    t_write(7'h2D, 8'h00, 8'h01, "R3");
    t_read(7'h2D, 8'hFF, 1'b1, "R5");
    t_read(7'h2D, 8'h00, 1'b0, "R5");
    // Pointer: Send Byte then repeated Receive Byte.
    t_send(7'h2D, 8'h42);
    t_recv(7'h2D, "R6");
    t_recv(7'h2D, "R6");
    // Mismatched transactions leave pointer alone.
    t_send(7'h6D, 8'h99);
    t_recv(7'h2D, "R8");
    // Truncations.
    t_write(7'h2D, 8'h20, 8'h5A, "R3");
    t_trunc(8'h20, 8'hA5, 0, 7);
    t_read(7'h2D, 8'h20, 1'b0, "R4");
    t_trunc(8'h20, 8'hA5, 1, 0);
    t_read(7'h2D, 8'h20, 1'b0, "R4");
    t_trunc(8'h20, 8'hA5, 2, 0);
    t_read(7'h2D, 8'h20, 1'b0, "R7");
    t_send(7'h2D, 8'h33);
    t_trunc(8'h90, 8'h00, 3, 5);
    t_recv(7'h2D, "R4");
    t_trunc(8'h21, 8'h00, 0, 0);
    t_recv(7'h2D, "R6");

    // Strap change without reset has no effect.
    a0_strap = 1'b0;
    t_write(7'h2C, 8'h12, 8'h12, "R1");
    t_read(7'h2D, 8'h12, 1'b0, "R1");
    // New reset with strap low.
    do_reset(1'b0);
    chk("R9", "reg_addr after second reset", reg_addr, 8'h00);
    t_recv(7'h2C, "R6");
    t_write(7'h2D, 8'h13, 8'h44, "R1");
    t_write(7'h2C, 8'h13, 8'h45, "R1");
    t_read(7'h2C, 8'h13, 1'b0, "R1");

    // Constrained random mix.
    for (int it = 0; it < 100; it++) begin
      oth = 7'($urandom);
      if (oth == own_of(a0_lat)) oth = oth ^ 7'h40;
      a = ($urandom_range(0, 3) == 0) ? oth : own_of(a0_lat);
      r = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      op = $urandom_range(0, 5);
      case (op)
        0: t_write(a, r, 8'($urandom), "R3");
        1: t_read(a, r, 1'($urandom), "R5");
        2: t_send(a, r);
        3: t_recv(a, "R6");
        4: t_trunc(r, 8'($urandom), $urandom_range(0, 3), $urandom_range(0, 7));
        default: begin t_write(a, r, 8'($urandom), "R3"); t_read(own_of(a0_lat), r, 1'b0, "R3"); end
      endcase
    end

    wt(10);
    chk("R3", "write strobe count", we_cnt, exp_we);
    chk("R10", "SDA changes while SCL high", oe_bad, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d cycles", WD, WD);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule